// File: doc/BRIEF.md
# Interrupt Flag Controller

This block collects interrupt events for a small 8-bit processor core and turns them into one request line. Ten event sources each latch into their own sticky flag bit. Each flag has its own mask bit, and a master enable gates the whole set. The flags live in two byte-wide registers:

- a core register, which also holds three masks and the master enable;
- a peripheral flag register, which has a companion peripheral mask register.

Software reads and writes these registers through a simple address/data port. A fourth address returns the synchronized value of a general-purpose input port.

When the core accepts a request, it pulses an acknowledge. The block then clears the master enable. One cycle later it tells the core to push its return address and load the program counter with the fixed vector. A return-from-interrupt pulse sets the master enable again.

Two sources arrive from outside the clock domain:

- An external pin passes through a two-stage synchronizer and an edge detector. The edge polarity is selectable.
- A port-change source compares the synchronized port against a copy that is refreshed whenever software reads the port.

The other eight sources are single-cycle pulses from on-chip peripherals.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every flag, every mask bit and the master enable read 0, and irqReq, pushRet and vecLoad are low.
- R2: A source event sets its flag on the next clock edge, whatever the state of its mask bit or of the master enable. Only a software write clears a flag. When a write clears a flag in the same cycle as an event for that flag, the flag ends up set.
- R3: The registers are mapped as follows, and a write stores the written value in every writable bit:
  - Address 0: bit 0 is the port-change flag, bit 1 the external-pin flag, bit 2 the timer-0 flag, bits 3 to 5 their masks in the same order, bit 6 reads 0 and bit 7 is the master enable.
  - Address 1: bits 0 to 6 hold the peripheral flags, indexed like periphEvt (comparator, conversion done, timer-1, timer-2 match, EEPROM write, clock failure, capture/compare), and bit 7 reads 0.
  - Address 2: holds the matching peripheral masks in the same bit positions.
  - Address 3: returns the synchronized port, zero-extended.
- R4: irqReq is high exactly when the master enable is set and at least one flag has its mask bit set, except in the case covered by R9.
- R5: When irqAck is high at a clock edge, the master enable reads 0 after that edge. pushRet and vecLoad are then high for exactly one cycle, with vecAddr equal to 0x0004.
- R6: A retfie pulse without irqAck sets the master enable on the next edge.
- R7: The external-pin flag is set by a rising pin edge when edgeSel is 1 and by a falling edge when edgeSel is 0. It becomes visible after the third rising clock edge that follows the pin change, and not after the second. The opposite edge has no effect.
- R8: The port-change flag becomes set three clock edges after the port differs from the stored copy. A read of address 3 with regRdEn high returns the synchronized port and refreshes the copy, so that once the port is unchanged the flag stays clear after software clears it.
- R9: During a cycle in which software writes address 0 with bit 7 at 0, irqReq is held low. Any pending flags stay set and raise irqReq again once the master enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of address 3 refreshes the port copy) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| extPin | input | 1 | Asynchronous external interrupt pin |
| edgeSel | input | 1 | 1 = rising edge, 0 = falling edge on extPin |
| portIn | input | PORT_W | Asynchronous port watched for change |
| tmr0Ovf | input | 1 | Timer-0 overflow pulse |
| periphEvt | input | 7 | Peripheral event pulses, bit order as in R3 |
| irqAck | input | 1 | Core accepts the interrupt |
| retfie | input | 1 | Core executes return-from-interrupt |
| irqReq | output | 1 | Interrupt request to the core |
| pushRet | output | 1 | Core must push its return address |
| vecLoad | output | 1 | Core must load vecAddr into the program counter |
| vecAddr | output | PC_W | Interrupt vector address (0 when vecLoad is low) |

## Verification
The assertions assume that the core raises irqAck only while irqReq is high. They also assume that irqAck and retfie are never high in the same cycle, and that each event input is a single-cycle pulse. The directed tasks keep to these assumptions: they raise irqAck only after they have seen irqReq high, and they pulse retfie on its own. Register writes, port reads and events are driven on falling clock edges, so every pulse lasts exactly one cycle. The only overlaps the tasks create on purpose are an event with a clear of the same flag, and a write that clears the master enable while a request is pending.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W    = 8;
  localparam int CORE_SRC = 3;
  localparam int PERI_SRC = 7;
  localparam int NUM_SRC  = CORE_SRC + PERI_SRC;

  // Source index order; the core-register bit positions follow it.
  localparam int SRC_PORT = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_TMR0 = 2;

  localparam int GIE_BIT  = 7;

  localparam logic [1:0] ADDR_CORE  = 2'd0;
  localparam logic [1:0] ADDR_PFLAG = 2'd1;
  localparam logic [1:0] ADDR_PEN   = 2'd2;
  localparam logic [1:0] ADDR_PORT  = 2'd3;

  typedef struct packed {
    logic wrCore;
    logic wrPflag;
    logic wrPen;
    logic rdPort;
    logic gieSet;
    logic gieClr;
  } ctl_strobe_t;
endpackage

// File: rtl/irq_flag_datapath.sv
module irq_flag_datapath
  import irq_flag_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_strobe_t         strb,
  input  logic [REG_W-1:0]    wrData,
  input  logic [1:0]          rdAddr,
  input  logic                extPin,
  input  logic                edgeSel,
  input  logic [PORT_W-1:0]   portIn,
  input  logic                tmr0Ovf,
  input  logic [PERI_SRC-1:0] periphEvt,
  output logic [REG_W-1:0]    rdData,
  output logic                gie,
  output logic                anyPend,
  output logic [NUM_SRC-1:0]  flags
);
  logic extS1, extS2, extPrev, extEdge;
  logic [PORT_W-1:0] portS1, portS2, portCopy;
  logic portDiff;
  logic [NUM_SRC-1:0] evt, wrHit, wrBit, enHit, enBit, enables;

  // Pin synchronizer and edge detector.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extS1   <= 1'b0;
      extS2   <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extS1   <= extPin;
      extS2   <= extS1;
      extPrev <= extS2;
    end
  end
  assign extEdge = edgeSel ? (extS2 & ~extPrev) : (~extS2 & extPrev);

  // Port synchronizer and the copy taken on each port read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      portS1   <= '0;
      portS2   <= '0;
      portCopy <= '0;
    end else begin
      portS1 <= portIn;
      portS2 <= portS1;
      if (strb.rdPort) portCopy <= portS2;
    end
  end
  assign portDiff = (portS2 != portCopy);

  assign evt[SRC_PORT]         = portDiff;
  assign evt[SRC_EXT]          = extEdge;
  assign evt[SRC_TMR0]         = tmr0Ovf;
  assign evt[NUM_SRC-1:CORE_SRC] = periphEvt;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < CORE_SRC) begin : g_core
      assign wrHit[i] = strb.wrCore;
      assign wrBit[i] = wrData[i];
      assign enHit[i] = strb.wrCore;
      assign enBit[i] = wrData[i+CORE_SRC];
    end else begin : g_peri
      assign wrHit[i] = strb.wrPflag;
      assign wrBit[i] = wrData[i-CORE_SRC];
      assign enHit[i] = strb.wrPen;
      assign enBit[i] = wrData[i-CORE_SRC];
    end

    // Event has priority over a software write of the same flag.
    always_ff @(posedge clk) begin
      if (!rstN)         flags[i] <= 1'b0;
      else if (evt[i])   flags[i] <= 1'b1;
      else if (wrHit[i]) flags[i] <= wrBit[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN)         enables[i] <= 1'b0;
      else if (enHit[i]) enables[i] <= enBit[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             gie <= 1'b0;
    else if (strb.gieClr)  gie <= 1'b0;
    else if (strb.gieSet)  gie <= 1'b1;
    else if (strb.wrCore)  gie <= wrData[GIE_BIT];
  end

  assign anyPend = |(flags & enables);

  always_comb begin
    unique case (rdAddr)
      ADDR_CORE:  rdData = {gie, 1'b0, enables[CORE_SRC-1:0], flags[CORE_SRC-1:0]};
      ADDR_PFLAG: rdData = {1'b0, flags[NUM_SRC-1:CORE_SRC]};
      ADDR_PEN:   rdData = {1'b0, enables[NUM_SRC-1:CORE_SRC]};
      default:    rdData = REG_W'(portS2);
    endcase
  end
endmodule

// File: rtl/irq_flag_control.sv
module irq_flag_control
  import irq_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic        wrGieBit,
  input  logic        irqAck,
  input  logic        retfie,
  input  logic        gie,
  input  logic        anyPend,
  output ctl_strobe_t strb,
  output logic        irqReq,
  output logic        pushRet,
  output logic        vecLoad
);
  logic suppress;
  logic ackQ;

  always_comb begin
    strb.wrCore  = regWrEn && (regAddr == ADDR_CORE);
    strb.wrPflag = regWrEn && (regAddr == ADDR_PFLAG);
    strb.wrPen   = regWrEn && (regAddr == ADDR_PEN);
    strb.rdPort  = regRdEn && (regAddr == ADDR_PORT);
    strb.gieSet  = retfie;
    strb.gieClr  = irqAck;
  end

  // A write that drops the master enable masks the request in that cycle.
  assign suppress = strb.wrCore && !wrGieBit;
  assign irqReq   = gie && anyPend && !suppress;

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= irqAck;
  end

  assign pushRet = ackQ;
  assign vecLoad = ackQ;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int              PORT_W = 6,
  parameter int              PC_W   = 13,
  parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regAddr,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                extPin,
  input  logic                edgeSel,
  input  logic [PORT_W-1:0]   portIn,
  input  logic                tmr0Ovf,
  input  logic [6:0]          periphEvt,
  input  logic                irqAck,
  input  logic                retfie,
  output logic                irqReq,
  output logic                pushRet,
  output logic                vecLoad,
  output logic [PC_W-1:0]     vecAddr
);
  ctl_strobe_t        strb;
  logic               gieQ;
  logic               anyPend;
  logic [NUM_SRC-1:0] flagQ;

  irq_flag_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .wrGieBit (regWrData[GIE_BIT]),
    .irqAck   (irqAck),
    .retfie   (retfie),
    .gie      (gieQ),
    .anyPend  (anyPend),
    .strb     (strb),
    .irqReq   (irqReq),
    .pushRet  (pushRet),
    .vecLoad  (vecLoad)
  );

  irq_flag_datapath #(.PORT_W(PORT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .extPin    (extPin),
    .edgeSel   (edgeSel),
    .portIn    (portIn),
    .tmr0Ovf   (tmr0Ovf),
    .periphEvt (periphEvt),
    .rdData    (regRdData),
    .gie       (gieQ),
    .anyPend   (anyPend),
    .flags     (flagQ)
  );

  assign vecAddr = vecLoad ? VECTOR : '0;
endmodule

// File: rtl/irq_flag_checker.sv
module irq_flag_checker
  import irq_flag_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         regAddr,
  input logic               regWrEn,
  input logic               wrGieBit,
  input logic               irqAck,
  input logic               retfie,
  input logic               tmr0Ovf,
  input logic               irqReq,
  input logic               pushRet,
  input logic               vecLoad,
  input logic               gie,
  input logic [NUM_SRC-1:0] flags
);
  p_req_needs_gie_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> gie);

  p_ack_clears_gie_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> (!gie && vecLoad && pushRet));

  p_vec_after_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    vecLoad |-> $past(irqAck));

  p_retfie_sets_gie_r6: assert property (@(posedge clk) disable iff (!rstN)
    (retfie && !irqAck) |=> gie);

  p_tmr0_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    tmr0Ovf |=> flags[SRC_TMR0]);

  p_flags_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((flags & $past(flags)) == $past(flags)));

  p_clear_suppress_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CORE && !wrGieBit) |-> !irqReq);
endmodule

bind irq_flag_ctrl irq_flag_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .wrGieBit (regWrData[7]),
  .irqAck   (irqAck),
  .retfie   (retfie),
  .tmr0Ovf  (tmr0Ovf),
  .irqReq   (irqReq),
  .pushRet  (pushRet),
  .vecLoad  (vecLoad),
  .gie      (gieQ),
  .flags    (flagQ)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  localparam int PORT_W = 6;
  localparam int PC_W   = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic extPin = 1'b0, edgeSel = 1'b0;
  logic [PORT_W-1:0] portIn = '0;
  logic tmr0Ovf = 1'b0;
  logic [6:0] periphEvt = '0;
  logic irqAck = 1'b0, retfie = 1'b0;
  logic irqReq, pushRet, vecLoad;
  logic [PC_W-1:0] vecAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl #(.PORT_W(PORT_W), .PC_W(PC_W)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .extPin(extPin), .edgeSel(edgeSel), .portIn(portIn), .tmr0Ovf(tmr0Ovf),
    .periphEvt(periphEvt), .irqAck(irqAck), .retfie(retfie), .irqReq(irqReq),
    .pushRet(pushRet), .vecLoad(vecLoad), .vecAddr(vecAddr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseRetfie();
    @(negedge clk); retfie = 1'b1;
    @(negedge clk); retfie = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], d);
      check("R1 reg", {8'h0, d}, 16'h0);
    end
    check("R1 irqReq", {15'h0, irqReq}, 16'h0);
    check("R1 vecLoad", {14'h0, vecLoad, pushRet}, 16'h0);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    @(negedge clk); tmr0Ovf = 1'b1; periphEvt = 7'b0001000;
    @(negedge clk); tmr0Ovf = 1'b0; periphEvt = '0;
    peek(2'd0, d); check("R2 masked tmr0 flag", {8'h0, d}, 16'h0004);
    peek(2'd1, d); check("R3 periph flag bit3", {8'h0, d}, 16'h0008);
    check("R4 no req with gie clear", {15'h0, irqReq}, 16'h0);
  endtask

  task automatic t_request();
    logic [7:0] d;
    wrReg(2'd2, 8'h08);
    check("R4 enabled but gie clear", {15'h0, irqReq}, 16'h0);
    wrReg(2'd0, 8'h84);
    check("R4 req raised", {15'h0, irqReq}, 16'h1);
    peek(2'd0, d); check("R3 core readback", {8'h0, d}, 16'h0084);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    check("R5 vecLoad/pushRet", {14'h0, vecLoad, pushRet}, 16'h3);
    check("R5 vecAddr", {3'h0, vecAddr}, 16'h0004);
    check("R5 req dropped", {15'h0, irqReq}, 16'h0);
    peek(2'd0, d); check("R5 gie cleared", {8'h0, d}, 16'h0004);
    @(negedge clk);
    check("R5 single pulse", {14'h0, vecLoad, pushRet}, 16'h0);
    peek(2'd1, d); check("R2 flag pending after ack", {8'h0, d}, 16'h0008);
  endtask

  task automatic t_retfie();
    logic [7:0] d;
    pulseRetfie();
    peek(2'd0, d); check("R6 gie set by retfie", {8'h0, d}, 16'h0084);
    check("R6 req back", {15'h0, irqReq}, 16'h1);
    wrReg(2'd1, 8'h00);
    check("R4 req gone after flag clear", {15'h0, irqReq}, 16'h0);
    wrReg(2'd2, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    @(negedge clk);
    regAddr = 2'd0; regWrData = 8'h80; regWrEn = 1'b1; tmr0Ovf = 1'b1;
    @(negedge clk); regWrEn = 1'b0; tmr0Ovf = 1'b0;
    peek(2'd0, d); check("R2 event beats clear core", {8'h0, d}, 16'h0084);
    @(negedge clk);
    regAddr = 2'd1; regWrData = 8'h00; regWrEn = 1'b1; periphEvt = 7'b1000000;
    @(negedge clk); regWrEn = 1'b0; periphEvt = '0;
    peek(2'd1, d); check("R2 event beats clear periph", {8'h0, d}, 16'h0040);
    wrReg(2'd1, 8'h00);
    peek(2'd1, d); check("R2 software clear", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_suppress();
    logic [7:0] d;
    wrReg(2'd0, 8'hA4);
    check("R4 tmr0 request", {15'h0, irqReq}, 16'h1);
    @(negedge clk);
    regAddr = 2'd0; regWrData = 8'h24; regWrEn = 1'b1;
    #1 check("R9 req masked during clear", {15'h0, irqReq}, 16'h0);
    @(negedge clk); regWrEn = 1'b0;
    check("R9 req low after clear", {15'h0, irqReq}, 16'h0);
    peek(2'd0, d); check("R9 flag kept", {8'h0, d}, 16'h0024);
    pulseRetfie();
    check("R9 pending served later", {15'h0, irqReq}, 16'h1);
    wrReg(2'd0, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    edgeSel = 1'b0;
    @(negedge clk); extPin = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd0, d); check("R7 rising ignored in falling mode", {8'h0, d}, 16'h0);
    @(negedge clk); extPin = 1'b0;
    @(negedge clk); @(negedge clk);
    peek(2'd0, d); check("R7 falling not yet at 2", {8'h0, d}, 16'h0);
    @(negedge clk);
    peek(2'd0, d); check("R7 falling at 3", {8'h0, d}, 16'h0002);
    wrReg(2'd0, 8'h00);
    edgeSel = 1'b1;
    @(negedge clk); extPin = 1'b1;
    @(negedge clk); @(negedge clk);
    peek(2'd0, d); check("R7 rising not yet at 2", {8'h0, d}, 16'h0);
    @(negedge clk);
    peek(2'd0, d); check("R7 rising at 3", {8'h0, d}, 16'h0002);
    wrReg(2'd0, 8'h00);
    @(negedge clk); extPin = 1'b0;
    repeat (4) @(negedge clk);
    peek(2'd0, d); check("R7 falling ignored in rising mode", {8'h0, d}, 16'h0);
  endtask

  task automatic t_port();
    logic [7:0] d;
    @(negedge clk); portIn = 6'h15;
    @(negedge clk); @(negedge clk);
    peek(2'd0, d); check("R8 not yet at 2", {8'h0, d}, 16'h0);
    @(negedge clk);
    peek(2'd0, d); check("R8 change flag at 3", {8'h0, d}, 16'h0001);
    @(negedge clk); regAddr = 2'd3; regRdEn = 1'b1;
    #1 check("R8 port read value", {8'h0, regRdData}, 16'h0015);
    @(negedge clk); regRdEn = 1'b0;
    wrReg(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    peek(2'd0, d); check("R8 stays clear after read", {8'h0, d}, 16'h0);
    @(negedge clk); portIn = 6'h00;
    repeat (3) @(negedge clk);
    peek(2'd0, d); check("R8 change back sets flag", {8'h0, d}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_request();
    t_ack();
    t_retfie();
    t_race();
    t_suppress();
    t_ext();
    t_port();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule